// File: doc/BRIEF.md
# Cache way replacement selector

This block picks the way to evict from a 1- to 4-way set-associative cache when a line must be refilled. It sees the line index of the current lookup, a hit strobe with the way that hit, a refill strobe, and the per-way valid and lock bits of the addressed line. From these it presents, combinationally, the victim way for that line and a flag that says whether any eviction is allowed at all. Tag compare, the data arrays and the bus side of the refill are outside the block.

The replacement policy is a build-time parameter: a free-running counter (random), a one-bit per-line "replaced last" flag for two ways (least-recently-replaced), or a per-line recency ordering (least-recently-used). The recency ordering of each line is stored as a compact code: one bit for two ways, three bits for the six orderings of three ways, five bits for the twenty-four orderings of four ways. An accepted refill always installs into the way shown on `victim_o` in that cycle. The history states are those orderings. A hit moves the hit way to the most-recent end. An accepted refill moves the victim way there. Reset puts every line into the ordering 0,1,2,3 with way 0 the oldest.

Top module: `way_victim_sel`

## Requirements
- R1: With WAYS=1 the victim is always way 0, and `evict_o` is high exactly when way 0 is unlocked; with 3 ways the victim index never exceeds 2.
- R2: Under every policy, if some way is both invalid and unlocked, the victim is the lowest-numbered such way.
- R3: A locked way is never the victim; when every way is locked `evict_o` is low, and a refill in that state leaves the history unchanged.
- R4: Random policy: a counter resets to 0 and advances on every clock after reset, cycling 0,1 for 2 ways, 0,1,2 for 3 ways (value 3 skipped) and 0..3 for 4 ways; with all ways valid the victim is the first unlocked way found from the counter value upward, wrapping to way 0.
- R5: Least-recently-replaced policy (legal only with WAYS=2): each line holds a flag naming the way to replace next, reset to 0; an accepted refill sets it to the way other than `victim_o`; hits have no effect; the victim is the flagged way if unlocked, otherwise the other way.
- R6: Least-recently-used policy: each line keeps a recency ordering of its ways; a hit makes `hit_way_i` the most recent, an accepted refill makes `victim_o` the most recent, and with all ways valid the victim is the least recent unlocked way.
- R7: Every one of the 6 (3-way) or 24 (4-way) orderings is kept exactly in 3 or 5 history bits per line (1 bit for 2 ways), and an update changes only the line at `line_idx_i`.
- R8: After reset every line has ordering way 0 (oldest), 1, 2, 3 (newest) and every flag and counter is zero, so way 0 is the first victim.
- R9: History updates take effect at the next rising clock edge; when a hit and an accepted refill arrive in the same cycle the refill decides the update and the hit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_idx_i | input | IW | Line index of the current lookup |
| hit_i | input | 1 | A hit on the indexed line this cycle |
| hit_way_i | input | WW | Way that hit |
| refill_i | input | 1 | Refill of the indexed line into `victim_o` this cycle |
| way_valid_i | input | WAYS | Valid bit of each way of the indexed line |
| way_lock_i | input | WAYS | Lock bit of each way of the indexed line |
| victim_o | output | WW | Way to evict for the indexed line |
| evict_o | output | 1 | High when at least one way may be evicted |

## Verification
The properties take for granted that `hit_way_i` names an existing way, that the hit strobe is not raised for a line whose lookup missed in the same cycle as its refill unless the refill should win, and that the line index, valid and lock inputs are settled before each rising edge. The bench drives only way numbers below the configured associativity and changes every input in the low half of the clock. It sweeps every valid and lock combination between edges against an ordering model kept per line. Five configurations run side by side so that each policy and the 1-, 2-, 3- and 4-way cases are all exercised.

// File: rtl/way_sel_pkg.sv
`timescale 1ns/1ps
package way_sel_pkg;

    typedef enum logic [1:0] {
        POL_RANDOM = 2'd0,
        POL_LRR    = 2'd1,
        POL_LRU    = 2'd2
    } repl_pol_e;

    // Four 2-bit way slots; slot 0 is evicted first, slot WAYS-1 last.
    typedef logic [7:0] way_list_t;

    function automatic int perm_weight(input int k);
        case (k)
            2:       return 2;
            3:       return 6;
            default: return 1;
        endcase
    endfunction

    function automatic int hist_bits(input int ways, input repl_pol_e pol);
        if (pol == POL_LRU)
            return (ways == 4) ? 5 : (ways == 3) ? 3 : 1;
        return 1;
    endfunction

    // Ranked code -> ordering (factorial number system).
    function automatic way_list_t lru_decode(input logic [4:0] code, input int n);
        logic [1:0] pool [4];
        int         rest;
        int         pos;
        way_list_t  ord;
        ord  = '0;
        rest = int'(code);
        for (int q = 0; q < 4; q++) pool[q] = 2'(q);
        for (int p = 0; p < 4; p++) begin
            if (p < n) begin
                pos  = rest / perm_weight(n - 1 - p);
                rest = rest % perm_weight(n - 1 - p);
                ord[2*p +: 2] = pool[pos[1:0]];
                for (int q = 0; q < 3; q++)
                    if (q >= pos) pool[q] = pool[q + 1];
            end
        end
        return ord;
    endfunction

    // Ordering -> ranked code.
    function automatic logic [4:0] lru_encode(input way_list_t ord, input int n);
        int acc;
        int cnt;
        acc = 0;
        for (int p = 0; p < 4; p++) begin
            if (p < n - 1) begin
                cnt = 0;
                for (int q = 0; q < 4; q++)
                    if (q > p && q < n && ord[2*q +: 2] < ord[2*p +: 2]) cnt++;
                acc += cnt * perm_weight(n - 1 - p);
            end
        end
        return 5'(acc);
    endfunction

    // Move way w to the most-recent slot.
    function automatic way_list_t lru_touch(input way_list_t ord, input logic [1:0] w, input int n);
        way_list_t res;
        int        k;
        res = '0;
        k   = 0;
        for (int p = 0; p < 4; p++) begin
            if (p < n && ord[2*p +: 2] != w && k < n - 1) begin
                res[2*k +: 2] = ord[2*p +: 2];
                k++;
            end
        end
        res[2*(n-1) +: 2] = w;
        return res;
    endfunction

endpackage

// File: rtl/way_rand_ctr.sv
`timescale 1ns/1ps
module way_rand_ctr #(
    parameter int  WAYS = 4,
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [WW-1:0] ctr_o
);
    localparam logic [WW-1:0] LAST = WW'(WAYS - 1);

    logic [WW-1:0] ctr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ctr_q <= '0;
        else if (ctr_q == LAST) ctr_q <= '0;
        else                    ctr_q <= ctr_q + 1'b1;
    end

    assign ctr_o = ctr_q;
endmodule

// File: rtl/way_hist_bank.sv
`timescale 1ns/1ps
module way_hist_bank
    import way_sel_pkg::*;
#(
    parameter int        WAYS   = 4,
    parameter int        LINES  = 64,
    parameter repl_pol_e POLICY = POL_LRU,
    localparam int       IW     = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int       WW     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int       HW     = hist_bits(WAYS, POLICY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx_i,
    input  logic          touch_i,
    input  logic [WW-1:0] touch_way_i,
    input  logic          fill_i,
    input  logic [WW-1:0] fill_way_i,
    output logic [HW-1:0] hist_o
);
    logic [HW-1:0] hist_q [LINES];
    logic [HW-1:0] hist_d;
    logic          upd;
    way_list_t     cur_ord;
    way_list_t     nxt_ord;

    assign hist_o = hist_q[idx_i];

    always_comb begin
        upd     = 1'b0;
        hist_d  = hist_o;
        cur_ord = lru_decode(5'(hist_o), WAYS);
        nxt_ord = cur_ord;
        if (POLICY == POL_LRR) begin
            if (fill_i) begin
                upd       = 1'b1;
                hist_d    = '0;
                hist_d[0] = ~fill_way_i[0];
            end
        end else begin
            // refill outranks a hit in the same cycle
            if (fill_i) begin
                upd     = 1'b1;
                nxt_ord = lru_touch(cur_ord, 2'(fill_way_i), WAYS);
            end else if (touch_i) begin
                upd     = 1'b1;
                nxt_ord = lru_touch(cur_ord, 2'(touch_way_i), WAYS);
            end
            hist_d = HW'(lru_encode(nxt_ord, WAYS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) hist_q[i] <= '0;
        end else if (upd) begin
            hist_q[idx_i] <= hist_d;
        end
    end
endmodule

// File: rtl/way_pick.sv
`timescale 1ns/1ps
module way_pick
    import way_sel_pkg::*;
#(
    parameter int  WAYS = 4,
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  way_list_t       order_i,
    input  logic [WAYS-1:0] valid_i,
    input  logic [WAYS-1:0] lock_i,
    output logic [WW-1:0]   victim_o,
    output logic            evict_o
);
    logic [3:0] lk4;
    logic       found;

    always_comb begin
        lk4 = '1;
        for (int w = 0; w < WAYS; w++) lk4[w] = lock_i[w];
        evict_o  = ~&lock_i;
        victim_o = '0;
        found    = 1'b0;
        // empty unlocked way first, lowest index
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_i[w] && !lock_i[w]) begin
                victim_o = WW'(w);
                found    = 1'b1;
            end
        end
        // then the policy preference list, skipping locked ways
        for (int k = 0; k < WAYS; k++) begin
            if (!found && !lk4[order_i[2*k +: 2]]) begin
                victim_o = WW'(order_i[2*k +: 2]);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/way_victim_sel.sv
`timescale 1ns/1ps
module way_victim_sel
    import way_sel_pkg::*;
#(
    parameter int        WAYS   = 4,
    parameter int        LINES  = 64,
    parameter repl_pol_e POLICY = POL_LRU,
    localparam int       IW     = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int       WW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   line_idx_i,
    input  logic            hit_i,
    input  logic [WW-1:0]   hit_way_i,
    input  logic            refill_i,
    input  logic [WAYS-1:0] way_valid_i,
    input  logic [WAYS-1:0] way_lock_i,
    output logic [WW-1:0]   victim_o,
    output logic            evict_o
);
    way_list_t pref;
    logic      fill_go;

    assign fill_go = refill_i & evict_o;

    generate
        if (WAYS == 1) begin : g_direct
            assign pref = '0;
        end else if (POLICY == POL_RANDOM) begin : g_rand
            logic [WW-1:0] ctr;
            way_rand_ctr #(.WAYS(WAYS)) u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .ctr_o (ctr)
            );
            always_comb begin
                pref = '0;
                for (int k = 0; k < WAYS; k++)
                    pref[2*k +: 2] = 2'((int'(ctr) + k) % WAYS);
            end
        end else begin : g_hist
            localparam int HW = hist_bits(WAYS, POLICY);
            logic [HW-1:0] hist;
            way_hist_bank #(
                .WAYS   (WAYS),
                .LINES  (LINES),
                .POLICY (POLICY)
            ) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .idx_i       (line_idx_i),
                .touch_i     (hit_i),
                .touch_way_i (hit_way_i),
                .fill_i      (fill_go),
                .fill_way_i  (victim_o),
                .hist_o      (hist)
            );
            if (POLICY == POL_LRR) begin : g_lrr
                assign pref = {4'b0000, 1'b0, ~hist[0], 1'b0, hist[0]};
            end else begin : g_lru
                assign pref = lru_decode(5'(hist), WAYS);
            end
        end
    endgenerate

    way_pick #(.WAYS(WAYS)) u_pick (
        .order_i  (pref),
        .valid_i  (way_valid_i),
        .lock_i   (way_lock_i),
        .victim_o (victim_o),
        .evict_o  (evict_o)
    );
endmodule

// File: rtl/way_victim_chk.sv
`timescale 1ns/1ps
module way_victim_chk
    import way_sel_pkg::*;
#(
    parameter int        WAYS   = 4,
    parameter int        LINES  = 64,
    parameter repl_pol_e POLICY = POL_LRU,
    localparam int       IW     = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int       WW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IW-1:0]   line_idx_i,
    input logic            hit_i,
    input logic [WW-1:0]   hit_way_i,
    input logic            refill_i,
    input logic [WAYS-1:0] way_valid_i,
    input logic [WAYS-1:0] way_lock_i,
    input logic [WW-1:0]   victim_o,
    input logic            evict_o
);
    p_victim_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evict_o |-> !way_lock_i[victim_o]);

    p_empty_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_o && |(~way_valid_i & ~way_lock_i)) |-> !way_valid_i[victim_o]);

    generate
        if (WAYS == 3) begin : g_range
            p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
                victim_o != 2'd3);
        end
        if (WAYS > 1 && POLICY == POL_RANDOM) begin : g_rand
            p_ctr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (&way_valid_i) && !(|way_lock_i)
                 && $past(&way_valid_i) && !$past(|way_lock_i))
                |-> victim_o != $past(victim_o));
        end
        if (WAYS > 1 && POLICY != POL_RANDOM) begin : g_hold
            p_locked_fill_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(refill_i) && $past(&way_lock_i) && !$past(hit_i)
                 && $stable(line_idx_i) && $stable(way_valid_i) && $stable(way_lock_i))
                |-> $stable(victim_o));
        end
        if (WAYS == 2 && POLICY == POL_LRR) begin : g_lrr
            p_flag_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(refill_i && evict_o) && $stable(line_idx_i)
                 && (&way_valid_i) && !(|way_lock_i))
                |-> victim_o != $past(victim_o));
        end
        if (WAYS > 1 && POLICY == POL_LRU) begin : g_lru
            p_hit_not_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(hit_i) && !$past(refill_i) && $stable(line_idx_i)
                 && (&way_valid_i) && !(|way_lock_i))
                |-> victim_o != $past(hit_way_i));
            p_refill_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(hit_i && refill_i && evict_o) && $stable(line_idx_i)
                 && (&way_valid_i) && !(|way_lock_i))
                |-> victim_o != $past(victim_o));
        end
    endgenerate
endmodule

bind way_victim_sel way_victim_chk #(
    .WAYS   (WAYS),
    .LINES  (LINES),
    .POLICY (POLICY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_idx_i  (line_idx_i),
    .hit_i       (hit_i),
    .hit_way_i   (hit_way_i),
    .refill_i    (refill_i),
    .way_valid_i (way_valid_i),
    .way_lock_i  (way_lock_i),
    .victim_o    (victim_o),
    .evict_o     (evict_o)
);

// File: tb/sim_way_victim_sel.sv
`timescale 1ns/1ps
module sim_way_victim_sel;
    import way_sel_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int errs = 0;
    int checks = 0;
    int rcnt = 0;

    logic [2:0] idx = '0;
    logic [1:0] hway = '0;
    logic [3:0] vld = '1;
    logic [3:0] lck = '0;
    logic [4:0] hit_en = '0;
    logic [4:0] fill_en = '0;

    logic [1:0] v0, v2, v4;
    logic [0:0] v1, v3;
    logic       e0, e1, e2, e3, e4;

    int mdl [5][8][4];

    // 4-way LRU, 8 lines
    way_victim_sel #(.WAYS(4), .LINES(8), .POLICY(POL_LRU)) u0 (
        .clk(clk), .rst_n(rst_n), .line_idx_i(idx), .hit_i(hit_en[0]), .hit_way_i(hway),
        .refill_i(fill_en[0]), .way_valid_i(vld), .way_lock_i(lck), .victim_o(v0), .evict_o(e0));
    // 2-way least-recently-replaced, 4 lines
    way_victim_sel #(.WAYS(2), .LINES(4), .POLICY(POL_LRR)) u1 (
        .clk(clk), .rst_n(rst_n), .line_idx_i(idx[1:0]), .hit_i(hit_en[1]), .hit_way_i(hway[0]),
        .refill_i(fill_en[1]), .way_valid_i(vld[1:0]), .way_lock_i(lck[1:0]), .victim_o(v1), .evict_o(e1));
    // 3-way random, 4 lines
    way_victim_sel #(.WAYS(3), .LINES(4), .POLICY(POL_RANDOM)) u2 (
        .clk(clk), .rst_n(rst_n), .line_idx_i(idx[1:0]), .hit_i(hit_en[2]), .hit_way_i(hway),
        .refill_i(fill_en[2]), .way_valid_i(vld[2:0]), .way_lock_i(lck[2:0]), .victim_o(v2), .evict_o(e2));
    // direct mapped
    way_victim_sel #(.WAYS(1), .LINES(4), .POLICY(POL_LRU)) u3 (
        .clk(clk), .rst_n(rst_n), .line_idx_i(idx[1:0]), .hit_i(hit_en[3]), .hit_way_i(hway[0]),
        .refill_i(fill_en[3]), .way_valid_i(vld[0:0]), .way_lock_i(lck[0:0]), .victim_o(v3), .evict_o(e3));
    // 3-way LRU, 2 lines
    way_victim_sel #(.WAYS(3), .LINES(2), .POLICY(POL_LRU)) u4 (
        .clk(clk), .rst_n(rst_n), .line_idx_i(idx[0]), .hit_i(hit_en[4]), .hit_way_i(hway),
        .refill_i(fill_en[4]), .way_valid_i(vld[2:0]), .way_lock_i(lck[2:0]), .victim_o(v4), .evict_o(e4));

    always @(posedge clk) if (rst_n) rcnt <= rcnt + 1;

    task automatic read_out(input int inst, output logic [1:0] w, output logic e);
        case (inst)
            0:       begin w = v0;         e = e0; end
            1:       begin w = {1'b0, v1}; e = e1; end
            2:       begin w = v2;         e = e2; end
            3:       begin w = {1'b0, v3}; e = e3; end
            default: begin w = v4;         e = e4; end
        endcase
    endtask

    // expected outcome straight from R1/R2/R3 plus a policy preference list
    task automatic exp_pick(input int n, input int pref[4], input logic [3:0] v,
                            input logic [3:0] l, output int ew, output bit ee);
        bit found;
        ew = 0; ee = 0; found = 0;
        for (int w = 0; w < n; w++) if (!l[w]) ee = 1;
        if (ee) begin
            for (int w = 0; w < n; w++)
                if (!found && !v[w] && !l[w]) begin ew = w; found = 1; end
            for (int k = 0; k < n; k++)
                if (!found && !l[pref[k]]) begin ew = pref[k]; found = 1; end
        end
    endtask

    task automatic chk(input string req, input int inst, input int ew, input bit ee);
        logic [1:0] gw;
        logic       ge;
        read_out(inst, gw, ge);
        checks++;
        if (ge !== ee || (ee && gw !== 2'(ew))) begin
            errs++;
            $display("FAIL %s u%0d valid=%b lock=%b: victim=%0d evict=%b, expected victim=%0d evict=%0d",
                     req, inst, vld, lck, gw, ge, ew, ee);
        end
    endtask

    // all valid x lock combinations between two edges (R2, R3 and the policy)
    task automatic sweep(input int inst, input int n, input int pref[4], input string req);
        int ew;
        bit ee;
        for (int vm = 0; vm < (1 << n); vm++) begin
            for (int lm = 0; lm < (1 << n); lm++) begin
                vld = 4'(vm);
                lck = 4'(lm);
                #0.01;
                exp_pick(n, pref, vld, lck, ew, ee);
                chk(req, inst, ew, ee);
            end
        end
        vld = '1;
        lck = '0;
    endtask

    function automatic void touch(int inst, int line, int n, int w);
        int j;
        j = 0;
        for (int k = 0; k < n; k++)
            if (mdl[inst][line][k] != w) begin
                mdl[inst][line][j] = mdl[inst][line][k];
                j++;
            end
        mdl[inst][line][n-1] = w;
    endfunction

    task automatic lru_step(input int inst, input int n, input int line, input int hw,
                            input bit do_hit, input bit do_fill, input logic [3:0] lm,
                            input string req);
        int pref[4];
        int ew;
        bit ee;
        @(negedge clk);
        hit_en = '0; fill_en = '0;
        idx = 3'(line); hway = 2'(hw);
        for (int k = 0; k < 4; k++) pref[k] = mdl[inst][line][k];
        sweep(inst, n, pref, req);
        lck = lm;
        #0.01;
        exp_pick(n, pref, 4'hF, lm, ew, ee);
        hit_en[inst] = do_hit;
        fill_en[inst] = do_fill;
        @(posedge clk);
        if (do_fill && ee) touch(inst, line, n, ew);
        else if (do_hit)   touch(inst, line, n, hw);
    endtask

    task automatic idle();
        @(negedge clk);
        hit_en = '0; fill_en = '0; vld = '1; lck = '0;
    endtask

    initial begin
        int pref[4];
        int ew;
        bit ee;
        for (int i = 0; i < 5; i++)
            for (int l = 0; l < 8; l++)
                for (int k = 0; k < 4; k++) mdl[i][l][k] = k;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.01;
        // R8: every instance starts with way 0 as victim
        for (int i = 0; i < 5; i++) chk("R8 reset victim", i, 0, 1'b1);
        for (int k = 0; k < 4; k++) pref[k] = k;
        sweep(0, 4, pref, "R8 reset order");

        // R6/R7: every 4-long hit sequence on the 4-way LRU, lines rotating
        for (int s = 0; s < 256; s++)
            for (int j = 0; j < 4; j++)
                lru_step(0, 4, s % 8, (s >> (2*j)) & 3, 1'b1, 1'b0, 4'h0, "R7 4-way order");
        // R9: refills, some together with a hit; R3: some with locks, some all locked
        for (int s = 0; s < 48; s++)
            lru_step(0, 4, s % 8, (s + 1) % 4, (s % 3) == 0, 1'b1,
                     (s % 6 == 5) ? 4'hF : 4'((s * 5) % 16), "R9 refill");
        idle();

        // R6/R7: 3-way LRU, every 4-long hit sequence
        for (int s = 0; s < 81; s++)
            for (int j = 0; j < 4; j++)
                lru_step(4, 3, s % 2, (s / (j == 0 ? 1 : j == 1 ? 3 : j == 2 ? 9 : 27)) % 3,
                         1'b1, 1'b0, 4'h0, "R6 3-way order");
        for (int s = 0; s < 24; s++)
            lru_step(4, 3, s % 2, s % 3, (s % 4) == 1, 1'b1,
                     (s % 7 == 6) ? 4'h7 : 4'(s % 8), "R3 3-way refill");
        idle();

        // R5: least-recently-replaced flag, hits must not matter
        for (int s = 0; s < 48; s++) begin
            int f;
            logic [3:0] lm;
            @(negedge clk);
            hit_en = '0; fill_en = '0;
            idx = 3'(s % 4); hway = 2'(s % 2);
            f = mdl[1][s % 4][0];
            pref[0] = f; pref[1] = 1 - f; pref[2] = 0; pref[3] = 0;
            sweep(1, 2, pref, "R5 flag");
            lm = (s % 5 == 4) ? 4'h3 : (s % 5 == 3) ? 4'h1 : (s % 5 == 2) ? 4'h2 : 4'h0;
            lck = lm;
            #0.01;
            exp_pick(2, pref, 4'hF, lm, ew, ee);
            hit_en[1] = (s % 2) == 1;
            fill_en[1] = (s % 3) != 2;
            @(posedge clk);
            if (fill_en[1] && ee) mdl[1][s % 4][0] = 1 - ew;
        end
        idle();

        // R4: 3-way random counter, skips value 3
        for (int s = 0; s < 40; s++) begin
            int r;
            @(negedge clk);
            hit_en = '0; fill_en = '0;
            idx = 3'(s % 4); hway = 2'(s % 3);
            r = rcnt % 3;
            for (int k = 0; k < 3; k++) pref[k] = (r + k) % 3;
            pref[3] = 0;
            sweep(2, 3, pref, "R4 counter");
            hit_en[2] = (s % 2) == 0;
            fill_en[2] = (s % 3) == 0;
        end
        idle();

        // R1: direct mapped
        for (int s = 0; s < 12; s++) begin
            @(negedge clk);
            hit_en = '0; fill_en = '0;
            idx = 3'(s % 4);
            for (int k = 0; k < 4; k++) pref[k] = 0;
            sweep(3, 1, pref, "R1 one way");
            hit_en[3] = (s % 2) == 1;
            fill_en[3] = 1'b1;
        end
        idle();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1200000;
        errs++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule